// File: doc/BRIEF.md
# Peripheral Reset-and-Restart Sequencer

This block walks a peripheral through a fixed four-step restart using separate one-cycle control strobes, and confirms every step against a status bit before it moves on. A single trigger sets off the walk. The four steps run in a fixed order:

1. Raise the reset request.
2. Gate the clock off.
3. Release the reset.
4. Ungate the clock.

After each strobe the block polls the status bit that belongs to that step. Polling stops when the bit reaches the level the step expects, or when a bounded number of samples has been taken. The block then reports either a one-cycle completion pulse or a sticky error flag. The error comes with the 2-bit index of the step that did not settle.

The sequencer sits next to the system controller that owns the peripheral's reset and clock gating. Each control action has its own write-one strobe: the set and clear actions are separate wires, not one level. Each status input is a single bit. The poll limit is a parameter. It defaults to one million samples per step, and a small value can be used where short runs are wanted. A failure ends the walk at once, and no later step is started.

Top module: `periph_restart_seq`

## Requirements
- R1: After synchronous active-low reset the block is idle. The busy, done, error and all four strobe outputs are 0, and the failing-step index is 0.
- R2: A trigger taken while idle starts the walk. The strobes fire in this fixed order: reset request (step 0), clock off (step 1), reset release (step 2), clock on (step 3). Each strobe is a single-cycle pulse on entry to its step, and at most one strobe is high in any cycle.
- R3: Polling begins in the cycle after the strobe. A step passes when its status bit equals the level it expects: step 0 expects reset status 1, step 1 expects clock status 0, step 2 expects reset status 0 and step 3 expects clock status 1. A step that passes on poll sample n occupies n+1 cycles, counting its strobe cycle.
- R4: Each step allows at most POLL_LIMIT samples, and the sample count restarts at every step. A status bit that matches on sample POLL_LIMIT still passes.
- R5: A step that is still unmatched after POLL_LIMIT samples ends the walk. On that failure busy falls, the error flag rises, the failing-step index holds the step number (0 to 3), and no further strobe is issued.
- R6: On success, done is high for exactly one cycle, in the cycle in which busy is first low, and the error flag is 0.
- R7: A trigger that arrives while busy is ignored. It does not restart the walk, change the strobe order or change the timing.
- R8: The error flag and the failing-step index hold their values until the next accepted trigger. That trigger clears both to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Trigger for a restart walk |
| rst_stat_i | input | 1 | Reset status bit from the peripheral |
| clk_stat_i | input | 1 | Clock-running status bit from the peripheral |
| rst_req_o | output | 1 | Strobe: raise reset request (step 0) |
| clk_off_o | output | 1 | Strobe: gate clock off (step 1) |
| rst_rel_o | output | 1 | Strobe: release reset (step 2) |
| clk_on_o | output | 1 | Strobe: ungate clock (step 3) |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle pulse on successful completion |
| err_o | output | 1 | Sticky timeout error |
| err_step_o | output | 2 | Index of the step that timed out |

## Verification
The bench builds the block with POLL_LIMIT set to 6. At that value the exact sample-limit boundary can be reached in a few cycles: a status bit that answers on the sixth sample passes, and one that answers on the seventh fails. With the same value, every step can be made to time out cheaply, including the final clock-on step. A behavioural peripheral model answers each strobe after a delay chosen per step, or never answers. The bench predicts the total cycle count, the strobe order, the outcome and the failing step from those delays alone.

// File: rtl/rsq_pkg.sv
// Package: shared types and helpers for the restart sequencer.
// Assumes a fixed four-step walk; the step number doubles as strobe index.
package rsq_pkg;

    localparam int NUM_STEPS = 4;
    localparam int STEP_W    = 2;

    typedef enum logic [STEP_W-1:0] {
        STEP_RST_ON  = 2'd0,
        STEP_CLK_OFF = 2'd1,
        STEP_RST_OFF = 2'd2,
        STEP_CLK_ON  = 2'd3
    } step_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ISSUE = 2'd1,
        PH_POLL  = 2'd2
    } phase_e;

    // Level the status bit must reach to finish a step.
    function automatic logic want_level(step_e s);
        case (s)
            STEP_RST_ON:  want_level = 1'b1;
            STEP_CLK_OFF: want_level = 1'b0;
            STEP_RST_OFF: want_level = 1'b0;
            default:      want_level = 1'b1;
        endcase
    endfunction

    // True when the step is judged on the clock status rather than reset status.
    function automatic logic uses_clk_status(step_e s);
        uses_clk_status = (s == STEP_CLK_OFF) || (s == STEP_CLK_ON);
    endfunction

endpackage

// File: rtl/rsq_poll_timer.sv
// Poll timer: counts status samples within one step.
// Holds at zero while run_i is low, so it reloads on every step entry.
// expired_o flags the final permitted sample (count == LIMIT-1).
module rsq_poll_timer #(
    parameter int LIMIT = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expired_o
);
    localparam int CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_q;

    // Sample counter: cleared when not polling, saturates at the last sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired_o = run_i && (cnt_q == LAST);

    // Counter never passes the last permitted sample.
    assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // Counter restarts from zero whenever a step is not being polled.
    assert_count_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (cnt_q == '0));

endmodule

// File: rtl/rsq_status_check.sv
// Status check: selects the status bit that belongs to the current step
// and compares it with the level that step expects.
// Purely combinational; inputs are assumed already synchronous to clk.
module rsq_status_check
    import rsq_pkg::*;
(
    input  step_e step_i,
    input  logic  rst_stat_i,
    input  logic  clk_stat_i,
    output logic  match_o
);
    logic sel_bit;

    // Pick the status bit and test it against the expected level.
    always_comb begin
        sel_bit = uses_clk_status(step_i) ? clk_stat_i : rst_stat_i;
        match_o = (sel_bit == want_level(step_i));
    end

endmodule

// File: rtl/rsq_strobe_decode.sv
// Strobe decoder: turns (issue phase, step) into one-hot one-cycle strobes.
// Assumes the issue phase lasts exactly one cycle per step.
module rsq_strobe_decode
    import rsq_pkg::*;
#(
    parameter int N = NUM_STEPS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_i,
    input  logic [STEP_W-1:0] step_i,
    output logic [N-1:0]      strobe_o
);
    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_strobe
            // One strobe per step, live only in that step's issue cycle.
            assign strobe_o[gi] = issue_i && (step_i == STEP_W'(gi));
        end
    endgenerate

    // Never two control actions in the same cycle.
    assert_strobe_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strobe_o));

    // Every strobe is a single-cycle pulse.
    assert_strobe_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_o != '0) |=> (strobe_o == '0));

endmodule

// File: rtl/rsq_fsm.sv
// Sequencer FSM: idle -> (issue -> poll) x4 -> idle.
// Advances on a status match, aborts on timer expiry with the step recorded.
// Assumes match_i and expired_i are valid only while in the poll phase.
module rsq_fsm
    import rsq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        match_i,
    input  logic        expired_i,
    output step_e       step_o,
    output logic        issue_o,
    output logic        poll_o,
    output logic        busy_o,
    output logic        done_o,
    output logic        err_o,
    output logic [1:0]  err_step_o
);
    phase_e phase_q;
    step_e  step_q;
    logic   done_q, err_q;
    logic [1:0] err_step_q;

    // Main sequencing: step walk, completion pulse and sticky error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q    <= PH_IDLE;
            step_q     <= STEP_RST_ON;
            done_q     <= 1'b0;
            err_q      <= 1'b0;
            err_step_q <= 2'd0;
        end else begin
            done_q <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (start_i) begin
                        phase_q    <= PH_ISSUE;
                        step_q     <= STEP_RST_ON;
                        err_q      <= 1'b0;
                        err_step_q <= 2'd0;
                    end
                end
                PH_ISSUE: phase_q <= PH_POLL;
                PH_POLL: begin
                    if (match_i) begin
                        if (step_q == STEP_CLK_ON) begin
                            phase_q <= PH_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            step_q  <= step_e'(step_q + 2'd1);
                            phase_q <= PH_ISSUE;
                        end
                    end else if (expired_i) begin
                        phase_q    <= PH_IDLE;
                        err_q      <= 1'b1;
                        err_step_q <= step_q;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign step_o     = step_q;
    assign issue_o    = (phase_q == PH_ISSUE);
    assign poll_o     = (phase_q == PH_POLL);
    assign busy_o     = (phase_q != PH_IDLE);
    assign done_o     = done_q;
    assign err_o      = err_q;
    assign err_step_o = err_step_q;

    // Done is a single pulse, only when idle again and without error.
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_done_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && !err_o));

    // An unmatched final sample aborts the walk with the error raised.
    assert_timeout_abort_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_o && !match_i && expired_i) |=> (err_o && !busy_o));

    // Error and its step index hold until a new trigger is taken.
    assert_err_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !start_i) |=> (err_o && $stable(err_step_o)));

    // A trigger while busy never re-enters the first step.
    assert_no_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> !(issue_o && step_o == STEP_RST_ON));

endmodule

// File: rtl/periph_restart_seq.sv
// Top: peripheral reset-and-restart sequencer.
// Issues reset-request, clock-off, reset-release and clock-on strobes in turn,
// polling the matching status bit after each for up to POLL_LIMIT samples.
// Assumes status inputs are synchronous to clk.
module periph_restart_seq
    import rsq_pkg::*;
#(
    parameter int POLL_LIMIT = 1000000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       rst_stat_i,
    input  logic       clk_stat_i,
    output logic       rst_req_o,
    output logic       clk_off_o,
    output logic       rst_rel_o,
    output logic       clk_on_o,
    output logic       busy_o,
    output logic       done_o,
    output logic       err_o,
    output logic [1:0] err_step_o
);
    step_e                step;
    logic                 issue, poll, match, expired;
    logic [NUM_STEPS-1:0] strobes;

    rsq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .match_i    (match),
        .expired_i  (expired),
        .step_o     (step),
        .issue_o    (issue),
        .poll_o     (poll),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .err_o      (err_o),
        .err_step_o (err_step_o)
    );

    rsq_poll_timer #(.LIMIT(POLL_LIMIT)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (poll),
        .expired_o (expired)
    );

    rsq_status_check u_check (
        .step_i     (step),
        .rst_stat_i (rst_stat_i),
        .clk_stat_i (clk_stat_i),
        .match_o    (match)
    );

    rsq_strobe_decode #(.N(NUM_STEPS)) u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue_i  (issue),
        .step_i   (step),
        .strobe_o (strobes)
    );

    assign rst_req_o = strobes[STEP_RST_ON];
    assign clk_off_o = strobes[STEP_CLK_OFF];
    assign rst_rel_o = strobes[STEP_RST_OFF];
    assign clk_on_o  = strobes[STEP_CLK_ON];

endmodule

// File: tb/periph_restart_seq_test.sv
`timescale 1ns/1ps
module periph_restart_seq_test;
    localparam int L     = 6;
    localparam int NEVER = 255;
    localparam int WD    = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic rst_stat, clk_stat;
    logic rst_req, clk_off, rst_rel, clk_on, busy, done, err;
    logic [1:0] err_step;

    always #2.5 clk = ~clk;

    periph_restart_seq #(.POLL_LIMIT(L)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .rst_stat_i(rst_stat), .clk_stat_i(clk_stat),
        .rst_req_o(rst_req), .clk_off_o(clk_off),
        .rst_rel_o(rst_rel), .clk_on_o(clk_on),
        .busy_o(busy), .done_o(done), .err_o(err), .err_step_o(err_step)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int t_start = 0;
    int dly [4];

    typedef struct {
        bit         is_err;
        logic [1:0] step;
        int         elapsed;
        int         nstrobe;
        logic [7:0] order;
    } exp_t;
    exp_t exp_q[$];

    // Model state (single writer: the model process)
    int         pend;
    logic [1:0] pend_step;
    int         log_n;
    logic [7:0] log_ord;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Watchdog
    always @(posedge clk) begin
        if (cyc > WD) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, WD);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Peripheral model: answers each strobe after a per-step delay, logs strobes
    always @(posedge clk) begin : model
        logic [3:0] s;
        logic [1:0] idx;
        s = {clk_on, rst_rel, clk_off, rst_req};
        if (!rst_n || (start_i && !busy)) begin
            rst_stat <= 1'b0;
            clk_stat <= 1'b1;
            pend     <= 0;
            log_n    <= 0;
            log_ord  <= 8'h00;
        end else begin
            if (s != 4'b0) begin
                idx = s[1] ? 2'd1 : s[2] ? 2'd2 : s[3] ? 2'd3 : 2'd0;
                log_ord <= log_ord | (8'(idx) << (2 * log_n));
                log_n   <= log_n + 1;
                if (dly[idx] == 0) begin
                    case (idx)
                        2'd0: rst_stat <= 1'b1;
                        2'd1: clk_stat <= 1'b0;
                        2'd2: rst_stat <= 1'b0;
                        default: clk_stat <= 1'b1;
                    endcase
                    pend <= 0;
                end else if (dly[idx] >= NEVER) begin
                    pend <= 0;
                end else begin
                    pend <= dly[idx];
                    pend_step <= idx;
                end
            end else if (pend != 0) begin
                if (pend == 1) begin
                    case (pend_step)
                        2'd0: rst_stat <= 1'b1;
                        2'd1: clk_stat <= 1'b0;
                        2'd2: rst_stat <= 1'b0;
                        default: clk_stat <= 1'b1;
                    endcase
                end
                pend <= pend - 1;
            end
        end
    end

    // Monitor: on busy falling, pop expected result and compare
    logic prev_busy = 1'b0;
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && prev_busy && !busy) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 unexpected completion", 1, 0);
            end else begin
                e = exp_q.pop_front();
                check((cyc - t_start) == e.elapsed, "R3/R4 elapsed cycles", cyc - t_start, e.elapsed);
                check(err == e.is_err, "R5 error flag", err, e.is_err);
                check(done == !e.is_err, "R6 done pulse with busy low", done, !e.is_err);
                check(err_step == e.step, "R5 failing step index", err_step, e.step);
                check(log_n == e.nstrobe, "R2 strobe count", log_n, e.nstrobe);
                check(log_ord == e.order, "R2 strobe order", log_ord, e.order);
            end
        end
        prev_busy <= busy;
    end

    // Driver: computes expectations from the delays, then triggers
    task automatic run_seq(input int d0, input int d1, input int d2, input int d3,
                           input bit extra_trigger);
        exp_t e;
        int n;
        int k;
        int d [4];
        d[0] = d0; d[1] = d1; d[2] = d2; d[3] = d3;
        n = 0; k = 0;
        e.is_err = 1'b0; e.step = 2'd0; e.order = 8'h00;
        for (int i = 0; i < 4; i++) begin
            e.order = e.order | (8'(i) << (2 * i));
            k = i + 1;
            if (d[i] < L) begin
                n += d[i] + 2;
            end else begin
                n += 1 + L;
                e.is_err = 1'b1;
                e.step = 2'(i);
                break;
            end
        end
        e.elapsed = n + 1;
        e.nstrobe = k;
        e.order   = e.order & ((8'h01 << (2 * k)) - 8'h01);
        for (int i = 0; i < 4; i++) dly[i] = d[i];
        exp_q.push_back(e);
        @(negedge clk);
        start_i = 1'b1;
        t_start = cyc;
        @(negedge clk);
        start_i = 1'b0;
        if (extra_trigger) begin
            repeat (3) @(negedge clk);
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        wait (exp_q.size() == 0);
        repeat (2) @(negedge clk);
        check(done == 1'b0, "R6 done lasts one cycle", done, 0);
        check(busy == 1'b0, "R7 no restart after completion", busy, 0);
        check(err == e.is_err, "R8 error flag held", err, e.is_err);
        check(err_step == e.step, "R8 step index held", err_step, e.step);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) dly[i] = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(busy == 0, "R1 busy after reset", busy, 0);
        check(done == 0, "R1 done after reset", done, 0);
        check(err == 0, "R1 err after reset", err, 0);
        check(err_step == 0, "R1 err_step after reset", err_step, 0);
        check({rst_req, clk_off, rst_rel, clk_on} == 4'b0, "R1 strobes after reset",
              {rst_req, clk_off, rst_rel, clk_on}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 0, "R1 idle without trigger", busy, 0);

        run_seq(0, 0, 0, 0, 1'b0);          // R2 R3 R6 fastest walk
        run_seq(2, 0, 3, 1, 1'b0);          // R3 mixed delays
        run_seq(0, L - 1, 0, 0, 1'b0);      // R4 match on last sample passes
        run_seq(0, 0, L, 0, 1'b0);          // R4 R5 one sample too late fails at step 2
        repeat (5) @(negedge clk);
        check(err == 1 && err_step == 2, "R8 error still held while idle", err_step, 2);
        run_seq(NEVER, 0, 0, 0, 1'b0);     // R5 fail at step 0, R8 cleared first
        run_seq(1, 1, 1, 1, 1'b1);          // R7 trigger while busy ignored
        run_seq(0, 0, 0, NEVER, 1'b1);     // R5 fail at step 3, R7
        run_seq(L - 1, L - 1, L - 1, L - 1, 1'b0); // R4 counter reloads each step

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule